// File: doc/BRIEF.md
# Interrupt Vector Priority Resolver

This block decides which exception or interrupt vector the processor takes next. It reads six kinds of non-maskable exception requests, a parameterised set of maskable peripheral request lines and the external IRQ pin. It applies the processor's I and X mask bits and a fixed priority order, and it reports a pending flag with the low byte of the winning vector address. The vector table fills downward from 0xFE, and every vector sits on an even address.

Software can move one maskable source to the head of the maskable group. To do this it writes the low byte of that source's vector to a promotion register. Any value that does not name an implemented maskable vector promotes 0xF2 instead.

The external IRQ pin passes through a conditioning stage. That stage can disconnect the pin, or treat it as an active-low level or as a latched falling edge. Its setting can be written only once after each reset. Stacking and vector fetch belong to the processor and are not part of this block.

Top module: `irq_resolver`

## Requirements
- R1: Among the non-maskable sources the order is: reset request (vector 0xFE), then clock failure (0xFC), watchdog (0xFA), illegal-opcode trap (0xF8), XIRQ pin low (0xF4), and software interrupt (0xF6) last.
- R2: Any unmasked non-maskable request wins over every maskable request.
- R3: While iMask is 1, no maskable source, including the IRQ pin, is pending. XIRQ is blocked only when xMask is 1.
- R4: With no promotion in effect, maskable priority follows the vector address: the IRQ pin (0xF2) comes first, then intReq[k] with vector 0xF0 − 2k, where a lower k wins.
- R5: A promotion-register write while iMask is 1 takes effect from the next clock. The promoted source then beats every other maskable source, including the IRQ pin. A write while iMask is 0 is ignored.
- R6: The promotion register resets to 0xF2. A written value that is odd, above 0xF2 or below the lowest implemented vector (0xD2 for 16 lines) is stored as 0xF2.
- R7: In level mode (control bit0 = 0) with the pin connected, a low IRQ pin is a request in the same cycle.
- R8: In edge mode (control bit0 = 1), a falling edge of the IRQ pin becomes pending after the clock that samples it. It stays pending until irqAck is 1 at a clock edge. A steadily low pin raises no new request.
- R9: With control bit1 = 0, the IRQ pin is disconnected and raises no request in either mode.
- R10: The IRQ control register (bit1 connect, bit0 edge select) resets to connected and level mode. Only the first write after reset takes effect.
- R11: With nothing pending, intPending is 0 and vecLow is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rstReq | input | 1 | Reset exception request |
| clkFailReq | input | 1 | Clock failure exception request |
| wdogReq | input | 1 | Watchdog time-out request |
| trapReq | input | 1 | Illegal-opcode trap request |
| swiReq | input | 1 | Software interrupt request |
| xirqPin_n | input | 1 | XIRQ pin, active low |
| irqPin_n | input | 1 | IRQ pin, active low |
| intReq | input | NUM_REQ | Maskable peripheral request lines |
| iMask | input | 1 | I mask bit from the condition codes |
| xMask | input | 1 | X mask bit from the condition codes |
| hprioWr | input | 1 | Write strobe of the promotion register |
| intCtrlWr | input | 1 | Write strobe of the IRQ control register |
| wrData | input | 8 | Register write data |
| irqAck | input | 1 | Clears a latched IRQ falling edge |
| intPending | output | 1 | A vector is selected |
| vecLow | output | 8 | Low byte of the selected vector address |

## Verification
Arbitration is combinational. The bench therefore sets the request and mask inputs, waits one time step and samples intPending and vecLow with no clock in between.

A register write or an acknowledge takes effect only after the clock edge that captures it, so those checks run one step after that edge. An IRQ falling edge needs its own edge to be registered: the pin is driven low between edges and sampled after the next rising edge. Each check is taken well away from an active edge, so the result never depends on the order of processes at that edge.

// File: rtl/irq_resolver_pkg.sv
package irq_resolver_pkg;
  localparam logic [7:0] VEC_RESET = 8'hFE;
  localparam logic [7:0] VEC_CLKFAIL = 8'hFC;
  localparam logic [7:0] VEC_WDOG = 8'hFA;
  localparam logic [7:0] VEC_TRAP = 8'hF8;
  localparam logic [7:0] VEC_SWI = 8'hF6;
  localparam logic [7:0] VEC_XIRQ = 8'hF4;
  localparam logic [7:0] VEC_IRQPIN = 8'hF2;

  typedef struct packed {
    logic [7:0] promoVec;
    logic irqReq;
  } ctlStrobes_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_resolver_pkg::*;
#(
  parameter int NUM_REQ = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        iMask,
  input  logic        hprioWr,
  input  logic        intCtrlWr,
  input  logic [7:0]  wrData,
  input  logic        irqPin_n,
  input  logic        irqAck,
  output ctlStrobes_t strobes
);
  localparam int FLOOR_I = 240 - 2 * (NUM_REQ - 1);

  logic [7:0] promoReg;
  logic pinEnable, edgeSel, ctlLocked;
  logic pinPrev, edgeLatch;
  logic promoLegal, fallSeen;

  assign promoLegal = (wrData <= VEC_IRQPIN) && !wrData[0] && (int'(wrData) >= FLOOR_I);

  // promotion register: writable only while maskable interrupts are blocked
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) promoReg <= VEC_IRQPIN;
    else if (hprioWr && iMask) promoReg <= promoLegal ? wrData : VEC_IRQPIN;
  end

  // IRQ pin control, one write per reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pinEnable <= 1'b1;
      edgeSel <= 1'b0;
      ctlLocked <= 1'b0;
    end else if (intCtrlWr && !ctlLocked) begin
      pinEnable <= wrData[1];
      edgeSel <= wrData[0];
      ctlLocked <= 1'b1;
    end
  end

  assign fallSeen = pinEnable && edgeSel && pinPrev && !irqPin_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pinPrev <= 1'b1;
      edgeLatch <= 1'b0;
    end else begin
      pinPrev <= irqPin_n;
      edgeLatch <= fallSeen || (edgeLatch && !irqAck && pinEnable && edgeSel);
    end
  end

  always_comb begin
    strobes.promoVec = promoReg;
    strobes.irqReq = pinEnable && (edgeSel ? edgeLatch : !irqPin_n);
  end

  // R5: a write while the I bit is clear leaves the promotion unchanged
  p_promo_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hprioWr && !iMask) |=> $stable(promoReg));
  // R6: the stored promotion always names an implemented even vector
  p_promo_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !promoReg[0] && promoReg <= VEC_IRQPIN && int'(promoReg) >= FLOOR_I);
  // R10: once locked, control writes change nothing
  p_ctl_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlLocked && intCtrlWr) |=> ($stable(pinEnable) && $stable(edgeSel)));
  // R8: a latched edge survives until acknowledged
  p_edge_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (edgeLatch && !irqAck && pinEnable && edgeSel) |=> edgeLatch);
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_resolver_pkg::*;
#(
  parameter int NUM_REQ = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rstReq,
  input  logic               clkFailReq,
  input  logic               wdogReq,
  input  logic               trapReq,
  input  logic               swiReq,
  input  logic               xirqPin_n,
  input  logic [NUM_REQ-1:0] intReq,
  input  logic               iMask,
  input  logic               xMask,
  input  ctlStrobes_t        strobes,
  output logic               intPending,
  output logic [7:0]         vecLow
);
  localparam int NUM_M = NUM_REQ + 1;

  logic [NUM_M-1:0] mReq;
  logic [7:0] mVec [NUM_M];
  logic xirqLive, nmiAny;
  logic [7:0] nmiVec;
  logic maskAny, promoHit;
  logic [7:0] maskVec;

  // maskable slot 0 is the IRQ pin, slot k+1 is intReq[k]
  assign mReq[0] = strobes.irqReq;
  assign mVec[0] = VEC_IRQPIN;
  for (genvar k = 0; k < NUM_REQ; k++) begin : g_slot
    assign mReq[k+1] = intReq[k];
    assign mVec[k+1] = 8'(240 - 2 * k);
  end

  assign xirqLive = !xirqPin_n && !xMask;

  always_comb begin
    nmiAny = 1'b1;
    if (rstReq) nmiVec = VEC_RESET;
    else if (clkFailReq) nmiVec = VEC_CLKFAIL;
    else if (wdogReq) nmiVec = VEC_WDOG;
    else if (trapReq) nmiVec = VEC_TRAP;
    else if (xirqLive) nmiVec = VEC_XIRQ;
    else if (swiReq) nmiVec = VEC_SWI;
    else begin
      nmiVec = 8'h00;
      nmiAny = 1'b0;
    end
  end

  always_comb begin
    maskAny = 1'b0;
    maskVec = 8'h00;
    promoHit = 1'b0;
    for (int j = NUM_M - 1; j >= 0; j--) begin
      if (mReq[j]) begin
        maskAny = 1'b1;
        maskVec = mVec[j];
      end
    end
    for (int j = 0; j < NUM_M; j++) begin
      if (mReq[j] && mVec[j] == strobes.promoVec) promoHit = 1'b1;
    end
    if (iMask) maskAny = 1'b0;
    else if (promoHit) maskVec = strobes.promoVec;
  end

  always_comb begin
    intPending = nmiAny || maskAny;
    vecLow = nmiAny ? nmiVec : (maskAny ? maskVec : 8'h00);
  end

  // R1: a reset request always selects the top vector
  p_reset_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rstReq |-> (intPending && vecLow == VEC_RESET));
  // R3: with both masks set and no exception, nothing is pending
  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iMask && xMask && !rstReq && !clkFailReq && !wdogReq && !trapReq && !swiReq)
      |-> !intPending);
  // R11: idle output carries a zero vector; pending vectors are even
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!intPending |-> vecLow == 8'h00) and (intPending |-> !vecLow[0]));
  // R2: a requesting maskable source never beats the trap
  p_nmi_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trapReq && !rstReq && !clkFailReq && !wdogReq) |-> vecLow == VEC_TRAP);
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_resolver_pkg::*;
#(
  parameter int NUM_REQ = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rstReq,
  input  logic               clkFailReq,
  input  logic               wdogReq,
  input  logic               trapReq,
  input  logic               swiReq,
  input  logic               xirqPin_n,
  input  logic               irqPin_n,
  input  logic [NUM_REQ-1:0] intReq,
  input  logic               iMask,
  input  logic               xMask,
  input  logic               hprioWr,
  input  logic               intCtrlWr,
  input  logic [7:0]         wrData,
  input  logic               irqAck,
  output logic               intPending,
  output logic [7:0]         vecLow
);
  ctlStrobes_t strobes;

  irq_ctrl #(.NUM_REQ(NUM_REQ)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .iMask(iMask), .hprioWr(hprioWr),
    .intCtrlWr(intCtrlWr), .wrData(wrData), .irqPin_n(irqPin_n),
    .irqAck(irqAck), .strobes(strobes)
  );

  irq_datapath #(.NUM_REQ(NUM_REQ)) u_dp (
    .clk(clk), .rst_n(rst_n), .rstReq(rstReq), .clkFailReq(clkFailReq),
    .wdogReq(wdogReq), .trapReq(trapReq), .swiReq(swiReq),
    .xirqPin_n(xirqPin_n), .intReq(intReq), .iMask(iMask), .xMask(xMask),
    .strobes(strobes), .intPending(intPending), .vecLow(vecLow)
  );
endmodule

// File: tb/test_irq_resolver.sv
module test_irq_resolver;
  localparam int CLK_PERIOD = 10;
  localparam int NREQ = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rstReq = 0, clkFailReq = 0, wdogReq = 0, trapReq = 0, swiReq = 0;
  logic xirqPin_n = 1, irqPin_n = 1;
  logic [NREQ-1:0] intReq = '0;
  logic iMask = 0, xMask = 0, hprioWr = 0, intCtrlWr = 0, irqAck = 0;
  logic [7:0] wrData = 8'h00;
  logic intPending;
  logic [7:0] vecLow;
  int total = 0, bad = 0;
  bit finished = 0;

  irq_resolver #(.NUM_REQ(NREQ)) i_irq_resolver (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  // exc bits: [4] reset, [3] clock fail, [2] watchdog, [1] trap, [0] swi
  typedef struct packed {
    logic [4:0] exc;
    logic xLow;
    logic irqLow;
    logic [15:0] req;
    logic iM;
    logic xM;
    logic pend;
    logic [7:0] vec;
  } row_t;

  localparam row_t ROWS [14] = '{
    '{5'b00000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h00}, // R11
    '{5'b00000, 1'b0, 1'b0, 16'h0001, 1'b0, 1'b0, 1'b1, 8'hF0}, // R4
    '{5'b00000, 1'b0, 1'b0, 16'h8008, 1'b0, 1'b0, 1'b1, 8'hEA}, // R4
    '{5'b00000, 1'b0, 1'b1, 16'h0001, 1'b0, 1'b0, 1'b1, 8'hF2}, // R4 R7
    '{5'b00000, 1'b0, 1'b1, 16'h0001, 1'b1, 1'b0, 1'b0, 8'h00}, // R3
    '{5'b00000, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 8'hF4}, // R3
    '{5'b00000, 1'b1, 1'b0, 16'h0004, 1'b0, 1'b1, 1'b1, 8'hEC}, // R3
    '{5'b00001, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 8'hF4}, // R1
    '{5'b00001, 1'b0, 1'b1, 16'h00FF, 1'b1, 1'b0, 1'b1, 8'hF6}, // R2
    '{5'b00011, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 8'hF8}, // R1
    '{5'b00110, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 8'hFA}, // R1
    '{5'b01100, 1'b0, 1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b1, 8'hFC}, // R1 R2
    '{5'b11111, 1'b1, 1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b1, 8'hFE}, // R1
    '{5'b00000, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 8'h00}  // R3
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic ePend, input logic [7:0] eVec);
    total++;
    if (intPending !== ePend || vecLow !== eVec) begin
      bad++;
      $display("FAIL %s: pend=%0b vec=%02h expected pend=%0b vec=%02h",
               tag, intPending, vecLow, ePend, eVec);
    end
  endtask

  task automatic quiet();
    {rstReq, clkFailReq, wdogReq, trapReq, swiReq} = '0;
    xirqPin_n = 1; irqPin_n = 1; intReq = '0; iMask = 0; xMask = 0;
  endtask

  task automatic do_reset();
    quiet();
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
    tick();
  endtask

  task automatic write_promo(input logic [7:0] v, input logic im);
    iMask = im; wrData = v; hprioWr = 1;
    tick();
    hprioWr = 0; iMask = 0;
  endtask

  task automatic write_ctl(input logic [7:0] v);
    wrData = v; intCtrlWr = 1;
    tick();
    intCtrlWr = 0;
  endtask

  initial begin
    do_reset();
    #1 check("R11 reset idle", 1'b0, 8'h00);
    intReq[0] = 1; irqPin_n = 0;
    #1 check("R6 reset promo F2", 1'b1, 8'hF2);
    quiet();

    foreach (ROWS[n]) begin
      {rstReq, clkFailReq, wdogReq, trapReq, swiReq} = ROWS[n].exc;
      xirqPin_n = !ROWS[n].xLow;
      irqPin_n = !ROWS[n].irqLow;
      intReq = ROWS[n].req;
      iMask = ROWS[n].iM;
      xMask = ROWS[n].xM;
      #1 check($sformatf("R1-table row %0d", n), ROWS[n].pend, ROWS[n].vec);
    end
    quiet();

    // R5 promotion of intReq[8] (vector E0)
    write_promo(8'hE0, 1'b1);
    intReq[0] = 1; intReq[8] = 1;
    #1 check("R5 promoted E0", 1'b1, 8'hE0);
    irqPin_n = 0; intReq[0] = 0;
    #1 check("R5 promoted beats IRQ pin", 1'b1, 8'hE0);
    quiet();
    write_promo(8'hF0, 1'b0);
    intReq[0] = 1; intReq[8] = 1;
    #1 check("R5 write ignored with I clear", 1'b1, 8'hE0);
    quiet();

    // R6 invalid values fall back to F2
    write_promo(8'hF5, 1'b1);
    irqPin_n = 0; intReq[8] = 1;
    #1 check("R6 above F2", 1'b1, 8'hF2);
    quiet();
    write_promo(8'hD2, 1'b1);
    intReq[0] = 1; intReq[15] = 1;
    #1 check("R6 lowest legal D2", 1'b1, 8'hD2);
    quiet();
    write_promo(8'hD0, 1'b1);
    intReq[0] = 1; intReq[15] = 1;
    #1 check("R6 below floor", 1'b1, 8'hF0);
    quiet();
    write_promo(8'hE1, 1'b1);
    irqPin_n = 0; intReq[8] = 1;
    #1 check("R6 odd value", 1'b1, 8'hF2);
    quiet();

    // R8 edge mode
    write_ctl(8'h03);
    tick();
    irqPin_n = 0;
    #1 check("R8 not before edge clock", 1'b0, 8'h00);
    tick();
    check("R8 edge latched", 1'b1, 8'hF2);
    irqPin_n = 1; tick();
    check("R8 held after pin rises", 1'b1, 8'hF2);
    irqAck = 1; tick(); irqAck = 0;
    check("R8 cleared by ack", 1'b0, 8'h00);
    irqPin_n = 0; tick(); tick();
    check("R8 edge again", 1'b1, 8'hF2);
    irqAck = 1; tick(); irqAck = 0; tick();
    check("R8 steady low no request", 1'b0, 8'h00);

    // R10 second write ignored: level mode would make low pin pending
    write_ctl(8'h02);
    tick();
    check("R10 write once", 1'b0, 8'h00);
    quiet();

    // R9 disconnected pin
    do_reset();
    write_ctl(8'h00);
    irqPin_n = 0;
    #1 check("R9 level disconnected", 1'b0, 8'h00);
    irqPin_n = 1; tick(); irqPin_n = 0; tick();
    check("R9 edge disconnected", 1'b0, 8'h00);
    quiet();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule